// File: doc/BRIEF.md
# Binary-Field Divider, Shift-and-Merge Iteration

The block divides one element of the binary extension field GF(2^M) by another. Given a dividend g, a nonzero divisor h and an irreducible modulus polynomial f of degree M (a trinomial or pentanomial such as x^163 + x^7 + x^6 + x^3 + 1), it returns z = g · h^(-1) mod f. Elements are M-bit vectors in which bit i holds the coefficient of x^i. The modulus is a port with M+1 bits, and bit M is the leading coefficient.

A one-cycle start pulse captures the operands. The block then runs one step of the polynomial binary algorithm per clock on four working polynomials a, b, c and d, with a = h, b = f, c = g and d = 0 at the start. Degree bounds for a and b, with initial values M-1 and M, decide each step. When the constant coefficient of a is zero, a is divided by x and c is multiplied by x^(-1) mod f. Otherwise b is added into a before the division by x, and d is added into c before the multiplication by x^(-1). If the bound of a is below the bound of b, the old a and c are first moved into b and d and the two bounds are exchanged. The loop stops when the smaller bound reaches zero. The quotient is then d if a has become zero, and c otherwise. A done flag then rises, and both done and z hold until the next start.

Top module: `gfdiv_binary`

## Requirements
- R1: While reset (rst_n low) is applied, done_o reads 0 and z_o reads all zeros.
- R2: For any nonzero h_i and irreducible f_i with f_i[M] = 1, the value on z_o when done_o is high satisfies z·h ≡ g (mod f) under carry-free polynomial arithmetic, where bit i of each vector is the coefficient of x^i.
- R3: A start pulse sampled on clock edge E0 makes done_o rise on edge E(N+1). N is the number of binary-algorithm steps from the bounds M-1 for a and M for b, and N ≤ 2M-2. Until that edge, done_o reads 0 and z_o reads 0.
- R4: Once done_o is high, done_o and z_o stay constant until the next start pulse, whatever values g_i, h_i and f_i take in the meantime.
- R5: A start pulse restarts the block, whether it is idle, computing or done. On the next edge done_o falls to 0, z_o is cleared, and the new operands are used.
- R6: Boundary operands give their exact quotients: g = 0 gives z = 0, h = 1 gives z = g, and g = h gives z = 1.
- R7: The modulus is captured at the start pulse. Changes on f_i during a division do not alter its result, and different moduli give their own quotients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that captures operands and begins a division |
| g_i | input | M | Dividend g(x) |
| h_i | input | M | Divisor h(x), must be nonzero |
| f_i | input | M+1 | Modulus f(x), bit M is the leading coefficient |
| z_o | output | M | Quotient g·h^(-1) mod f, valid while done_o is high |
| done_o | output | 1 | High from the end of a division until the next start |

## Verification
The bench builds the divider with M = 8. At that size the expected quotient can be found by a brute-force search over all 256 field elements. This search is independent of the shift-and-merge iteration and checks each result. Two irreducible pentanomials of degree 8 are used, along with divisors whose bound comparisons send the step sequence down both the merge and the exchange branches. The exact step count N is derived in the bench from the bound rules alone, so the bench knows the edge on which done_o must rise and can check the outputs on every clock.

// File: rtl/gfdiv_pkg.sv
package gfdiv_pkg;

    // Which of the three update rules one iteration applies
    typedef enum logic [1:0] {
        STEP_SHIFT      = 2'd0,  // constant term of a is 0
        STEP_MERGE      = 2'd1,  // a odd, bound of a >= bound of b
        STEP_MERGE_SWAP = 2'd2   // a odd, bound of a < bound of b
    } step_kind_e;

endpackage

// File: rtl/gfdiv_xinv.sv
// Multiply an element by x^(-1) modulo a monic f with f0 = 1.
// fh carries coefficients f1..fM of the modulus.
module gfdiv_xinv #(
    parameter int M = 163
) (
    input  logic [M-1:0] v,
    input  logic [M-1:0] fh,
    output logic [M-1:0] y
);

    for (genvar i = 0; i < M - 1; i++) begin : g_coef
        assign y[i] = v[i+1] ^ (v[0] & fh[i]);
    end
    assign y[M-1] = v[0] & fh[M-1];

endmodule

// File: rtl/gfdiv_step.sv
// One combinational iteration of the binary division algorithm.
module gfdiv_step
    import gfdiv_pkg::*;
#(
    parameter int M  = 163,
    parameter int BW = 8
) (
    input  logic [M-1:0]  a,
    input  logic [M:0]    b,
    input  logic [M-1:0]  c,
    input  logic [M-1:0]  d,
    input  logic [M-1:0]  fh,
    input  logic [BW-1:0] alpha,
    input  logic [BW-1:0] beta,
    output logic [M-1:0]  a_n,
    output logic [M:0]    b_n,
    output logic [M-1:0]  c_n,
    output logic [M-1:0]  d_n,
    output logic [BW-1:0] alpha_n,
    output logic [BW-1:0] beta_n
);

    step_kind_e   kind;
    logic [M:0]   a_mix;
    logic [M-1:0] c_mix;

    always_comb begin
        if (!a[0])             kind = STEP_SHIFT;
        else if (alpha < beta) kind = STEP_MERGE_SWAP;
        else                   kind = STEP_MERGE;
    end

    assign a_mix = {1'b0, a} ^ (a[0] ? b : '0);
    assign a_n   = a_mix[M:1];
    assign c_mix = a[0] ? (c ^ d) : c;

    gfdiv_xinv #(.M(M)) u_xinv (
        .v  (c_mix),
        .fh (fh),
        .y  (c_n)
    );

    always_comb begin
        b_n     = b;
        d_n     = d;
        alpha_n = alpha - BW'(1);
        beta_n  = beta;
        case (kind)
            STEP_MERGE_SWAP: begin
                b_n     = {1'b0, a};
                d_n     = c;
                alpha_n = beta - BW'(1);
                beta_n  = alpha;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/gfdiv_binary.sv
module gfdiv_binary #(
    parameter int M = 163
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [M-1:0] g_i,
    input  logic [M-1:0] h_i,
    input  logic [M:0]   f_i,
    output logic [M-1:0] z_o,
    output logic         done_o
);

    localparam int BW = $clog2(M + 1);

    typedef struct packed {
        logic [M-1:0]  a;
        logic [M:0]    b;
        logic [M-1:0]  c;
        logic [M-1:0]  d;
        logic [M-1:0]  fh;
        logic [BW-1:0] alpha;
        logic [BW-1:0] beta;
        logic          busy;
        logic          done;
        logic [M-1:0]  z;
    } div_state_t;

    div_state_t    st_d, st_q;
    logic [BW-1:0] min_bound;
    logic [M-1:0]  a_s, c_s, d_s;
    logic [M:0]    b_s;
    logic [BW-1:0] alpha_s, beta_s;

    assign min_bound = (st_q.alpha < st_q.beta) ? st_q.alpha : st_q.beta;

    gfdiv_step #(.M(M), .BW(BW)) u_step (
        .a       (st_q.a),
        .b       (st_q.b),
        .c       (st_q.c),
        .d       (st_q.d),
        .fh      (st_q.fh),
        .alpha   (st_q.alpha),
        .beta    (st_q.beta),
        .a_n     (a_s),
        .b_n     (b_s),
        .c_n     (c_s),
        .d_n     (d_s),
        .alpha_n (alpha_s),
        .beta_n  (beta_s)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.a     = h_i;
            st_d.b     = f_i;
            st_d.c     = g_i;
            st_d.d     = '0;
            st_d.fh    = f_i[M:1];
            st_d.alpha = BW'(M - 1);
            st_d.beta  = BW'(M);
            st_d.busy  = 1'b1;
            st_d.done  = 1'b0;
            st_d.z     = '0;
        end else if (st_q.busy) begin
            if (min_bound != '0) begin
                st_d.a     = a_s;
                st_d.b     = b_s;
                st_d.c     = c_s;
                st_d.d     = d_s;
                st_d.alpha = alpha_s;
                st_d.beta  = beta_s;
            end else begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.z    = (st_q.a == '0) ? st_q.d : st_q.c;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign z_o    = st_q.z;
    assign done_o = st_q.done;

endmodule

// File: rtl/gfdiv_binary_chk.sv
module gfdiv_binary_chk #(
    parameter int M = 163
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [M-1:0] g_i,
    input logic [M-1:0] h_i,
    input logic [M:0]   f_i,
    input logic [M-1:0] z_o,
    input logic         done_o
);

    localparam int CW = $clog2(2 * M + 2) + 1;

    logic [M-1:0]  g_l, h_l;
    logic [M:0]    f_l;
    logic [CW-1:0] cnt;
    logic          run_v;

    function automatic logic [M-1:0] fmul(input logic [M-1:0] x, input logic [M-1:0] y,
                                          input logic [M:0] f);
        logic [M:0] acc;
        acc = '0;
        for (int i = M - 1; i >= 0; i--) begin
            acc = {acc[M-1:0], 1'b0};
            if (acc[M]) acc = acc ^ f;
            if (y[i])   acc = acc ^ {1'b0, x};
        end
        return acc[M-1:0];
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_l   <= '0;
            h_l   <= '0;
            f_l   <= '0;
            cnt   <= '0;
            run_v <= 1'b0;
        end else if (start_i) begin
            g_l   <= g_i;
            h_l   <= h_i;
            f_l   <= f_i;
            cnt   <= '0;
            run_v <= 1'b1;
        end else if (run_v && !done_o && cnt != '1) begin
            cnt <= cnt + CW'(1);
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_STATE: assert (!done_o && z_o == '0); // R1
        end
    end

    AST_QUOTIENT_OK: assert property (@(posedge clk) disable iff (!rst_n) ($rose(done_o) && h_l != '0) |-> fmul(z_o, h_l, f_l) == g_l); // R2

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (run_v && !done_o && !start_i) |-> cnt <= CW'(2 * M - 1)); // R3

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (done_o && !start_i) |=> (done_o && $stable(z_o))); // R4

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) start_i |=> (!done_o && z_o == '0)); // R5

endmodule

bind gfdiv_binary gfdiv_binary_chk #(.M(M)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .g_i     (g_i),
    .h_i     (h_i),
    .f_i     (f_i),
    .z_o     (z_o),
    .done_o  (done_o)
);

// File: tb/sim_gfdiv_binary.sv
module sim_gfdiv_binary;

    localparam int M = 8;
    localparam logic [M:0] F_A = 9'h11B;  // x^8+x^4+x^3+x+1
    localparam logic [M:0] F_B = 9'h11D;  // x^8+x^4+x^3+x^2+1

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [M-1:0] g_i = '0;
    logic [M-1:0] h_i = '0;
    logic [M:0]   f_i = F_A;
    logic [M-1:0] z_o;
    logic         done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    gfdiv_binary #(.M(M)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .g_i     (g_i),
        .h_i     (h_i),
        .f_i     (f_i),
        .z_o     (z_o),
        .done_o  (done_o)
    );

    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] x, input logic [M-1:0] y,
                                             input logic [M:0] f);
        logic [M:0] acc;
        acc = '0;
        for (int i = M - 1; i >= 0; i--) begin
            acc = {acc[M-1:0], 1'b0};
            if (acc[M]) acc = acc ^ f;
            if (y[i])   acc = acc ^ {1'b0, x};
        end
        return acc[M-1:0];
    endfunction

    // Exhaustive search for the unique z with z*h = g
    function automatic logic [M-1:0] ref_quot(input logic [M-1:0] g, input logic [M-1:0] h,
                                              input logic [M:0] f);
        for (int z = 0; z < (1 << M); z++) begin
            if (ref_mul(z[M-1:0], h, f) == g) return z[M-1:0];
        end
        return '0;
    endfunction

    // Step count from the bound rules only
    function automatic int ref_steps(input logic [M-1:0] h, input logic [M:0] f);
        int pa, pb, tmp, n;
        int al, be;
        pa = int'(h); pb = int'(f); al = M - 1; be = M; n = 0;
        while (al > 0) begin
            if ((pa % 2) == 0) begin
                pa = pa / 2; al = al - 1;
            end else if (al >= be) begin
                pa = (pa ^ pb) / 2; al = al - 1;
            end else begin
                tmp = pa; pa = (pa ^ pb) / 2; pb = tmp;
                tmp = al; al = be - 1; be = tmp;
            end
            n++;
        end
        return n;
    endfunction

    task automatic cmp(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic launch(input logic [M-1:0] g, input logic [M-1:0] h, input logic [M:0] f,
                          output int n, output logic [M-1:0] zq);
        @(negedge clk);
        g_i = g; h_i = h; f_i = f; start_i = 1'b1;
        n  = ref_steps(h, f);
        zq = ref_quot(g, h, f);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Check at the negedge after edge E_j for j in [j0, j1]
    task automatic track(input int n, input logic [M-1:0] zq, input int j0, input int j1,
                         input string tag, input bit scramble);
        for (int j = j0; j <= j1; j++) begin
            bit exp_done;
            exp_done = (j >= n + 1);
            cmp({tag, " done (R3)"}, int'(done_o), int'(exp_done));
            cmp({tag, " z (R2)"}, int'(z_o), exp_done ? int'(zq) : 0);
            if (scramble && exp_done) begin
                g_i = M'($urandom); h_i = M'($urandom);
                f_i = $urandom_range(0, 1) ? F_A : F_B;
            end
            @(negedge clk);
        end
    endtask

    task automatic run(input logic [M-1:0] g, input logic [M-1:0] h, input logic [M:0] f,
                       input string tag, input int extra, input bit scramble);
        int n;
        logic [M-1:0] zq;
        launch(g, h, f, n, zq);
        track(n, zq, 0, n + 1 + extra, tag, scramble);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        int n;
        logic [M-1:0] zq;

        // R1: reset state
        repeat (3) @(negedge clk);
        cmp("R1 done in reset", int'(done_o), 0);
        cmp("R1 z in reset", int'(z_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R1 done after release", int'(done_o), 0);
        cmp("R1 z after release", int'(z_o), 0);

        // R2: general operands, both moduli
        run(8'h57, 8'h83, F_A, "R2 a", 2, 1'b0);
        run(8'hC3, 8'h02, F_A, "R2 b", 1, 1'b0);
        run(8'h9E, 8'h80, F_B, "R2 c", 1, 1'b0);

        // R6: boundary operands
        run(8'h00, 8'h35, F_A, "R6 g zero", 1, 1'b0);
        run(8'hAB, 8'h01, F_A, "R6 h one", 1, 1'b0);
        run(8'hFF, 8'hFF, F_B, "R6 g equals h", 1, 1'b0);

        // R4: outputs held while inputs wander after done
        run(8'h1D, 8'h6A, F_A, "R4 hold", 6, 1'b1);

        // R5: restart during a division, then restart after done
        launch(8'h12, 8'h34, F_A, n, zq);
        track(n, zq, 0, 2, "R5 first", 1'b0);
        run(8'h77, 8'h0B, F_B, "R5 restart", 1, 1'b0);
        run(8'h40, 8'hE1, F_A, "R5 after done", 1, 1'b0);

        // R7: modulus port changed during the run has no effect
        launch(8'h5C, 8'h99, F_A, n, zq);
        f_i = F_B;
        track(n, zq, 0, n + 2, "R7 f change", 1'b0);
        run(8'h5C, 8'h99, F_B, "R7 other modulus", 1, 1'b0);

        // R2: pseudo-random operands over both moduli
        for (int k = 0; k < 24; k++) begin
            logic [M-1:0] gg, hh;
            gg = M'($urandom);
            hh = M'($urandom);
            if (hh == '0) hh = 8'h01;
            run(gg, hh, (k % 2 == 0) ? F_A : F_B, "R2 sweep", 0, 1'b0);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule